// File: doc/BRIEF.md
# JTAG Indirect Register Bridge

This block sits behind one data register of a JTAG test access port. It lets a debug host reach a small bank of on-chip registers that are not mapped onto the scan chain. The TAP controller outside the block supplies its capture, shift and update strobes, the TDI bit and the current instruction value. The instruction value picks which internal register is addressed. The block returns TDO and drives a one-cycle register bus in the system clock domain.

The same shift register carries three kinds of frame, and the two bits shifted in last say which kind it is. A full-length frame tagged as a write moves its lower bits into the selected register. A two-bit frame tagged as a read fetches that register into a holding latch. Any other frame is a poll. On capture, bit 0 always carries the busy flag, so a one-bit scan returns only busy. When the bridge is idle, the held read value sits just above busy, so a longer scan returns busy followed by the data.

Each accepted request crosses into the system clock domain through a toggle handshake. It performs one bus access there and then holds busy for a set number of system clocks before it acknowledges back.

Top module: `tap_ireg_bridge`

## Requirements
- R1: Shifting moves TDI into the most significant bit and sends bit 0 out on TDO, least significant bit first. After a capture, the first bit on TDO is the busy flag (1 = busy).
- R2: An update is a write request when the frame's top two bits (the last two bits shifted) are 2'b11. It then produces exactly one bus write: bus_sel equals the instruction value, and bus_wdata equals the DW bits shifted first.
- R3: An update is a read request when the top two bits are 2'b10, which is the two-bit frame 0 then 1. It produces exactly one bus read of the selected register, and bus_rdata is latched as the read value.
- R4: A capture while not busy loads the latched read value into bits DW..1, with the top bit 0. A DW+1 bit scan therefore returns busy=0 followed by the data, least significant bit first. Before any read, that data is zero.
- R5: Busy rises at the update that accepts a request, so the next scan shows busy=1. It falls only after the bus access and BUSY_CYC system clocks, counted from the bus strobe to the acknowledge toggle.
- R6: A capture while busy loads zero in the data bits.
- R7: A frame whose top two bits are 2'b00 or 2'b01 causes no bus access and leaves busy at 0.
- R8: A write or read frame that arrives while busy is dropped. It causes no extra bus access and no change to any register.
- R9: Only the instruction values 4'h4 (control), 4'h5 (scale), 4'h6 (address) and 4'h7 (data) are accepted. A request with any other instruction value causes no bus access.
- R10: Every bus strobe lasts one system clock, and bus_wr and bus_rd are never high together.
- R11: After reset TDO is 0, busy is 0, no bus strobe is issued, and the read value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, test clock domain |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, system domain |
| capture_dr | input | 1 | TAP is in the capture state for this data register |
| shift_dr | input | 1 | TAP is in the shift state for this data register |
| update_dr | input | 1 | TAP is in the update state for this data register |
| tdi | input | 1 | Serial data in |
| ir_sel | input | IR_W | Current instruction value, selects the register |
| tdo | output | 1 | Serial data out |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_sel | output | IR_W | Selected register |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data for bus_sel, sampled while bus_rd is high |

## Verification
The bench drives frames at the pin level through a modelled TAP sequence.

- **Full-length write frames with random data to all four registers.** These show that the data lands in the register named by the instruction value. Each write is followed by a read-back through a two-bit request and a DW+1 bit scan, which separates the data path from busy-bit placement.
- **A scan started immediately after a request.** This checks that busy rises and that the data bits are zero while busy.
- **Frames tagged 00 or 01, and requests with out-of-range instruction values.** A later read-back shows that these reach no register.
- **A second write sent while the first is still busy.** This confirms that a dropped request leaves both the strobe count and the register contents unchanged.

// File: rtl/tib_pkg.sv
package tib_pkg;
  typedef enum logic [1:0] {
    OP_POLL0 = 2'b00,
    OP_POLL1 = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } tib_op_e;

  // accepted selector window: control, scale, address, data
  localparam int SEL_BASE = 4;
  localparam int NUM_REGS = 4;
endpackage

// File: rtl/tib_sync.sv
module tib_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tib_tck_side.sv
module tib_tck_side
  import tib_pkg::*;
#(
  parameter int DW          = 16,
  parameter int IR_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  input  logic [IR_W-1:0] ir_sel,
  input  logic [DW-1:0]   rd_hold,
  input  logic            ack_tgl,
  output logic            tdo,
  output logic            busy,
  output logic            req_tgl,
  output logic [1:0]      req_op,
  output logic [IR_W-1:0] req_sel,
  output logic [DW-1:0]   req_data
);
  localparam int FW = DW + 2;

  logic [FW-1:0]   sr_q, sr_d;
  logic            tgl_d;
  logic [1:0]      op_d;
  logic [IR_W-1:0] sel_d;
  logic [DW-1:0]   data_d;
  logic            ack_s;
  logic            sel_ok;
  logic            op_ok;
  logic            accept;
  tib_op_e         frame_op;

  tib_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(tck), .rst_n(trst_n), .d(ack_tgl), .q(ack_s)
  );

  assign busy     = req_tgl ^ ack_s;
  assign frame_op = tib_op_e'(sr_q[FW-1:FW-2]);
  assign sel_ok   = (int'(ir_sel) >= SEL_BASE) && (int'(ir_sel) < SEL_BASE + NUM_REGS);
  assign op_ok    = (frame_op == OP_WRITE) || (frame_op == OP_READ);
  assign accept   = update_dr && !busy && op_ok && sel_ok;

  always_comb begin
    sr_d   = sr_q;
    tgl_d  = req_tgl;
    op_d   = req_op;
    sel_d  = req_sel;
    data_d = req_data;
    if (capture_dr) begin
      sr_d = {1'b0, (busy ? {DW{1'b0}} : rd_hold), busy};
    end else if (shift_dr) begin
      sr_d = {tdi, sr_q[FW-1:1]};
    end
    if (accept) begin
      tgl_d  = ~req_tgl;
      op_d   = sr_q[FW-1:FW-2];
      sel_d  = ir_sel;
      data_d = sr_q[DW-1:0];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q     <= '0;
      req_tgl  <= 1'b0;
      req_op   <= '0;
      req_sel  <= '0;
      req_data <= '0;
    end else begin
      sr_q     <= sr_d;
      req_tgl  <= tgl_d;
      req_op   <= op_d;
      req_sel  <= sel_d;
      req_data <= data_d;
    end
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/tib_sys_side.sv
module tib_sys_side
  import tib_pkg::*;
#(
  parameter int DW          = 16,
  parameter int IR_W        = 4,
  parameter int BUSY_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_tgl,
  input  logic [1:0]      req_op,
  input  logic [IR_W-1:0] req_sel,
  input  logic [DW-1:0]   req_data,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_wr,
  output logic            bus_rd,
  output logic [IR_W-1:0] bus_sel,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   rd_hold,
  output logic            ack_tgl
);
  localparam int CW = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYC - 1);

  logic          req_s, req_prev;
  logic          start;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_d;
  logic          strobe;

  tib_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign start  = req_s ^ req_prev;
  assign strobe = act_q && (cnt_q == '0);
  assign bus_wr = strobe && (req_op == OP_WRITE);
  assign bus_rd = strobe && (req_op == OP_READ);
  assign bus_sel   = req_sel;
  assign bus_wdata = req_data;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    ack_d = ack_tgl;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        cnt_d = '0;
      end
    end else if (cnt_q == LAST) begin
      act_d = 1'b0;
      ack_d = ~ack_tgl;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_prev <= req_s;
      act_q    <= act_d;
      cnt_q    <= cnt_d;
      ack_tgl  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_hold <= '0;
    else if (bus_rd) rd_hold <= bus_rdata;
  end
endmodule

// File: rtl/tap_ireg_bridge.sv
module tap_ireg_bridge #(
  parameter int DW          = 16,
  parameter int IR_W        = 4,
  parameter int BUSY_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  input  logic [IR_W-1:0] ir_sel,
  output logic            tdo,
  output logic            bus_wr,
  output logic            bus_rd,
  output logic [IR_W-1:0] bus_sel,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata
);
  logic            busy;
  logic            req_tgl;
  logic            ack_tgl;
  logic [1:0]      req_op;
  logic [IR_W-1:0] req_sel;
  logic [DW-1:0]   req_data;
  logic [DW-1:0]   rd_hold;

  tib_tck_side #(.DW(DW), .IR_W(IR_W), .SYNC_STAGES(SYNC_STAGES)) u_tck (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .ir_sel(ir_sel), .rd_hold(rd_hold),
    .ack_tgl(ack_tgl), .tdo(tdo), .busy(busy), .req_tgl(req_tgl),
    .req_op(req_op), .req_sel(req_sel), .req_data(req_data)
  );

  tib_sys_side #(.DW(DW), .IR_W(IR_W), .BUSY_CYC(BUSY_CYC),
                 .SYNC_STAGES(SYNC_STAGES)) u_sys (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .req_op(req_op),
    .req_sel(req_sel), .req_data(req_data), .bus_rdata(bus_rdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .rd_hold(rd_hold), .ack_tgl(ack_tgl)
  );
endmodule

// File: rtl/tib_chk.sv
module tib_chk
  import tib_pkg::*;
#(
  parameter int IR_W     = 4,
  parameter int BUSY_CYC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tck,
  input logic            trst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [IR_W-1:0] bus_sel,
  input logic            ack_tgl,
  input logic            req_tgl,
  input logic            busy,
  input logic            capture_dr,
  input logic            tdo
);
  logic [31:0] since;
  logic        ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= ack_tgl;
      if (bus_wr || bus_rd)   since <= 32'd1;
      else if (since != '0)   since <= since + 32'd1;
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> ((int'(bus_sel) >= SEL_BASE) && (int'(bus_sel) < SEL_BASE + NUM_REGS)));
  // R5
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tgl != ack_q) |-> (since == 32'(BUSY_CYC)));
  // R8
  no_req_busy_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (req_tgl != $past(req_tgl)) |-> !$past(busy));
  // R1
  cap_busy_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> (tdo == $past(busy)));
endmodule

bind tap_ireg_bridge tib_chk #(.IR_W(IR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .ack_tgl(ack_tgl), .req_tgl(req_tgl), .busy(busy),
  .capture_dr(capture_dr), .tdo(tdo)
);

// File: tb/tb_tap_ireg_bridge.sv
module tb_tap_ireg_bridge;
  localparam int DW       = 16;
  localparam int IR_W     = 4;
  localparam int BUSY_CYC = 100;
  localparam int FW       = DW + 2;

  logic clk, tck, rst_n, trst_n;
  logic capture_dr, shift_dr, update_dr, tdi;
  logic [IR_W-1:0] ir_sel;
  logic tdo, bus_wr, bus_rd;
  logic [IR_W-1:0] bus_sel;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] bank [4];
  logic [DW-1:0] exp_bank [4];
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [IR_W-1:0] last_sel;
  logic [DW-1:0]   last_data;

  tap_ireg_bridge #(.DW(DW), .IR_W(IR_W), .BUSY_CYC(BUSY_CYC)) dut (
    .tck(tck), .trst_n(trst_n), .clk(clk), .rst_n(rst_n),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .ir_sel(ir_sel), .tdo(tdo), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  initial tck = 1'b0;
  always #20 tck = ~tck;

  // register bank model behind the bus
  assign bus_rdata = bank[bus_sel[1:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank[i] <= '0;
    end else begin
      if (bus_wr) begin
        bank[bus_sel[1:0]] <= bus_wdata;
        wr_cnt    <= wr_cnt + 1;
        last_sel  <= bus_sel;
        last_data <= bus_wdata;
      end
      if (bus_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] wr_frame(input logic [1:0] op, input logic [DW-1:0] d);
    return {op, d};
  endfunction

  function automatic logic [DW:0] rd_expect(input logic [DW-1:0] d);
    return {d, 1'b0};
  endfunction

  task automatic scan(input logic [FW-1:0] din, input int len, output logic [FW-1:0] dout);
    dout = '0;
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      shift_dr = 1'b1;
      tdi = din[i];
      @(negedge tck);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  task automatic poll_idle(input string tag);
    logic [FW-1:0] d;
    int n = 0;
    do begin
      scan('0, 1, d);
      n++;
    end while (d[0] && n < 400);
    check(d[0] == 1'b0, tag, d[0], 0);
  endtask

  task automatic do_write(input logic [IR_W-1:0] sel, input logic [DW-1:0] data,
                          input logic [1:0] op, input bit ok);
    logic [FW-1:0] d;
    int w0;
    w0 = wr_cnt;
    ir_sel = sel;
    scan(wr_frame(op, data), FW, d);
    scan('0, 1, d);
    if (ok) begin
      check(d[0] == 1'b1, "R5 busy after write", d[0], 1);
      poll_idle("R5 busy clears");
      check(wr_cnt == w0 + 1, "R2 one strobe", wr_cnt, w0 + 1);
      check(last_sel == sel, "R2 bus_sel", last_sel, sel);
      check(last_data == data, "R2 bus_wdata", last_data, data);
      exp_bank[sel[1:0]] = data;
    end else begin
      check(d[0] == 1'b0, "R7 R9 no busy", d[0], 0);
      repeat (300) @(posedge clk);
      check(wr_cnt == w0, "R7 R9 no strobe", wr_cnt, w0);
    end
  endtask

  task automatic do_read(input logic [IR_W-1:0] sel);
    logic [FW-1:0] d;
    int r0;
    r0 = rd_cnt;
    ir_sel = sel;
    scan(wr_frame(2'b00, {{(DW-2){1'b0}}, 2'b10}), 2, d);
    scan('0, 1, d);
    check(d[0] == 1'b1, "R5 busy after read", d[0], 1);
    poll_idle("R5 read busy clears");
    check(rd_cnt == r0 + 1, "R3 one read strobe", rd_cnt, r0 + 1);
    scan('0, DW + 1, d);
    check(d[DW:0] == rd_expect(exp_bank[sel[1:0]]), "R4 R3 read data", d[DW:0],
          rd_expect(exp_bank[sel[1:0]]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [FW-1:0] d;
    logic [DW-1:0] v;
    int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) exp_bank[i] = '0;
    rst_n = 1'b0; trst_n = 1'b0;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
    ir_sel = 4'h4;
    repeat (5) @(negedge tck);
    rst_n = 1'b1; trst_n = 1'b1;
    @(negedge tck);

    // R11 reset state
    check(tdo == 1'b0, "R11 tdo reset", tdo, 0);
    check(wr_cnt == 0 && rd_cnt == 0, "R11 no strobes", wr_cnt + rd_cnt, 0);
    scan('0, DW + 1, d);
    check(d[DW:0] == '0, "R11 R4 idle readout zero", d[DW:0], 0);

    // R2 R3 R4 directed corners on each register
    do_write(4'h4, 16'hFFFF, 2'b11, 1'b1);
    do_write(4'h5, 16'h0001, 2'b11, 1'b1);
    do_write(4'h6, 16'h8000, 2'b11, 1'b1);
    do_write(4'h7, 16'hA5A5, 2'b11, 1'b1);
    for (int i = 4; i < 8; i++) do_read(IR_W'(i));

    // R7 poll-tagged frames ignored
    do_write(4'h5, 16'h1234, 2'b00, 1'b0);
    do_write(4'h5, 16'h4321, 2'b01, 1'b0);
    do_read(4'h5);

    // R9 selector outside the window
    do_write(4'h3, 16'hBEEF, 2'b11, 1'b0);
    do_write(4'h8, 16'hBEEF, 2'b11, 1'b0);
    do_read(4'h7);

    // R6 readout while busy, R8 frame while busy dropped
    w0 = wr_cnt;
    ir_sel = 4'h6;
    scan(wr_frame(2'b11, 16'h0F0F), FW, d);
    scan('0, DW + 1, d);
    check(d[DW:0] == {{DW{1'b0}}, 1'b1}, "R6 zero data while busy", d[DW:0], 1);
    scan(wr_frame(2'b11, 16'hDEAD), FW, d);
    poll_idle("R8 busy clears");
    exp_bank[2] = 16'h0F0F;
    repeat (300) @(posedge clk);
    check(wr_cnt == w0 + 1, "R8 single strobe", wr_cnt, w0 + 1);
    do_read(4'h6);

    // R1 R2 R3 constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic [IR_W-1:0] s;
      s = IR_W'(4 + ($urandom % 4));
      v = DW'($urandom);
      if ($urandom % 3 == 0) do_read(s);
      else do_write(s, v, 2'b11, 1'b1);
    end
    for (int i = 4; i < 8; i++) do_read(IR_W'(i));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule